// File: doc/BRIEF.md
# Chainable Address-Match Trigger Unit

This block holds a small set of hardware triggers that watch the addresses a processor core uses. Each trigger keeps a control word and a comparison value. It can watch instruction-fetch addresses, load addresses or store addresses, and it can be limited to selected privilege levels. When a qualified comparison succeeds, the trigger asks the core either to take a breakpoint exception or to enter debug mode. Two neighbouring triggers can be linked into a pair, so that an address window can be expressed with a lower bound and an upper bound.

Software reaches the triggers through three registers. An index register chooses a trigger. The control register and the data register then refer to that trigger. Writes take effect on the next clock edge. Reads and all match outputs are combinational, so a request appears in the same cycle as the access that causes it, before that access commits. Both access ports are evaluated in parallel every cycle.

Top module: `trig_unit`

## Requirements
- R1: Register address 0 is the index register. A write stores the index only when the value is below the trigger count N; otherwise the index is unchanged. Address 1 (control) and address 2 (data) refer to the indexed trigger. Address 3 reads zero, and writes to it are ignored.
- R2: The control word bits are: 0 execute enable, 1 store enable, 2 load enable, 3 user enable, 4 supervisor enable, 5 machine enable, 9:6 match mode, 10 chain, 11 action, XLEN-5 debug-only. All other bits read zero.
- R3: Match mode 0 compares for equality with the data value. Mode 2 fires on address >= data. Mode 3 fires on address < data. Every other mode never matches.
- R4: A trigger matches only when the enable bit for the current privilege (code 0 user, 1 supervisor, 3 machine; code 2 never) is set. The enable bit for the access kind must also be set: the fetch port is execute, and the load/store port is load or store according to its store flag.
- R5: A firing trigger with action 0 raises the breakpoint output of its port. With action 1 it raises the debug-entry output instead. Both outputs are combinational and low when the port's valid is low.
- R6: When triggers with different actions fire on the same port in the same cycle, only the debug-entry output is raised.
- R7: A trigger with its chain bit set produces no request of its own. Its successor fires only when both it and its successor match the same access.
- R8: A control write that sets chain stores chain as 0 in three cases: the previous trigger is chained, the next trigger is chained, or the trigger is the last one. The other fields are still written.
- R9: A control write that sets chain stores it as 1 only if debug mode is active or the next trigger's debug-only bit is clear.
- R10: Outside debug mode, control and data writes to a trigger whose debug-only bit is set are ignored. The debug-only bit can be set only by a write made in debug mode.
- R11: Each hit output bit is high when its trigger matches the fetch access or the load/store access, whether or not a chain suppresses the request.
- R12: After reset the index, every control word and every data value are zero, and no output is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_waddr | input | 2 | Register written (0 index, 1 control, 2 data) |
| csr_wdata | input | XLEN | Write value |
| csr_raddr | input | 2 | Register read |
| csr_rdata | output | XLEN | Read value (combinational) |
| in_debug | input | 1 | Core is in debug mode |
| priv | input | 2 | Current privilege code |
| if_valid | input | 1 | Fetch access present |
| if_addr | input | XLEN | Fetch address |
| ls_valid | input | 1 | Load/store access present |
| ls_store | input | 1 | Load/store access is a store |
| ls_addr | input | XLEN | Load/store address |
| hit | output | N | Per-trigger match flags |
| if_bkpt | output | 1 | Breakpoint request for the fetch |
| if_dbg | output | 1 | Debug-entry request for the fetch |
| ls_bkpt | output | 1 | Breakpoint request for the load/store |
| ls_dbg | output | 1 | Debug-entry request for the load/store |

## Verification
The assertions assume that every input is known and steady at each active edge. They also assume that a register write lasts exactly one cycle while in_debug holds the value meant for that write. The bench changes inputs only on the falling edge and keeps the write strobe high for a single cycle, with in_debug set in the same step. Random addresses and data values are drawn from a narrow range, and control words are masked to the defined fields with a random debug-only bit. This keeps equality, boundary and chain cases frequent, so the locking and chaining properties are exercised often.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the trigger unit: register addresses, privilege
// codes, match mode codes, control bit positions and the stored control record.
package trig_pkg;

    typedef enum logic [1:0] {
        RA_SEL  = 2'd0,
        RA_CTRL = 2'd1,
        RA_DATA = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        PRV_U   = 2'd0,
        PRV_S   = 2'd1,
        PRV_RSV = 2'd2,
        PRV_M   = 2'd3
    } priv_e;

    localparam logic [3:0] MM_EQ = 4'd0;
    localparam logic [3:0] MM_GE = 4'd2;
    localparam logic [3:0] MM_LT = 4'd3;

    localparam int unsigned CB_EXE   = 0;
    localparam int unsigned CB_ST    = 1;
    localparam int unsigned CB_LD    = 2;
    localparam int unsigned CB_U     = 3;
    localparam int unsigned CB_S     = 4;
    localparam int unsigned CB_M     = 5;
    localparam int unsigned CB_MATCH = 6;
    localparam int unsigned CB_CHAIN = 10;
    localparam int unsigned CB_ACT   = 11;

    typedef struct packed {
        logic       dmode;
        logic       action;
        logic       chain;
        logic [3:0] mmode;
        logic       en_m;
        logic       en_s;
        logic       en_u;
        logic       en_ld;
        logic       en_st;
        logic       en_x;
    } trig_ctrl_t;

endpackage

// File: rtl/trig_match.sv
`timescale 1ns/1ps
// One trigger's comparator for one access port.
// Assumes the control record is already legal; unknown match modes never hit.
module trig_match
    import trig_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  trig_ctrl_t        ctrl,
    input  logic [XLEN-1:0]   tval,
    input  logic              acc_valid,
    input  logic [XLEN-1:0]   acc_addr,
    input  logic              acc_x,
    input  logic              acc_ld,
    input  logic              acc_st,
    input  logic [1:0]        priv,
    output logic              match
);

    logic priv_ok;
    logic kind_ok;
    logic cmp_ok;

    // Privilege qualification from the current privilege code.
    always_comb begin
        unique case (priv_e'(priv))
            PRV_U:   priv_ok = ctrl.en_u;
            PRV_S:   priv_ok = ctrl.en_s;
            PRV_M:   priv_ok = ctrl.en_m;
            default: priv_ok = 1'b0;
        endcase
    end

    // Access-kind qualification.
    assign kind_ok = (acc_x & ctrl.en_x) | (acc_ld & ctrl.en_ld) | (acc_st & ctrl.en_st);

    // Address comparison selected by the match mode.
    always_comb begin
        if (ctrl.mmode == MM_EQ)
            cmp_ok = (acc_addr == tval);
        else if (ctrl.mmode == MM_GE)
            cmp_ok = (acc_addr >= tval);
        else if (ctrl.mmode == MM_LT)
            cmp_ok = (acc_addr < tval);
        else
            cmp_ok = 1'b0;
    end

    assign match = acc_valid & priv_ok & kind_ok & cmp_ok;

endmodule

// File: rtl/trig_resolve.sv
`timescale 1ns/1ps
// Turns per-trigger matches of one port into breakpoint / debug requests.
// Applies pair chaining (a chained trigger gates its successor) and gives
// debug entry precedence over breakpoint. Assumes no two adjacent chain bits.
module trig_resolve
    import trig_pkg::*;
#(
    parameter int N = 4
) (
    input  trig_ctrl_t [N-1:0] ctrl,
    input  logic [N-1:0]       m,
    output logic               bkpt,
    output logic               dbg
);

    logic [N-1:0] fire;
    logic [N-1:0] act;

    for (genvar i = 0; i < N; i++) begin : g_fire
        logic gate_ok;
        // Predecessor in a chain must match as well.
        if (i > 0) begin : g_prev
            assign gate_ok = !ctrl[i-1].chain || m[i-1];
        end else begin : g_first
            assign gate_ok = 1'b1;
        end
        // A chained trigger produces no request of its own.
        assign fire[i] = m[i] && !ctrl[i].chain && gate_ok;
        assign act[i]  = ctrl[i].action;
    end

    assign dbg  = |(fire & act);
    assign bkpt = |(fire & ~act) && !dbg;

endmodule

// File: rtl/trig_regs.sv
`timescale 1ns/1ps
// Register file of the trigger unit: index register plus per-trigger control
// and data, with the debug-only lock and chain legality rules on write.
// Assumes writes come from machine mode or debug mode.
module trig_regs
    import trig_pkg::*;
#(
    parameter int N    = 4,
    parameter int XLEN = 32,
    localparam int SW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  csr_we,
    input  logic [1:0]            csr_waddr,
    input  logic [XLEN-1:0]       csr_wdata,
    input  logic [1:0]            csr_raddr,
    input  logic                  in_debug,
    output logic [XLEN-1:0]       csr_rdata,
    output logic [SW-1:0]         sel_o,
    output trig_ctrl_t [N-1:0]    ctrl_o,
    output logic [N-1:0][XLEN-1:0] data_o
);

    localparam int unsigned DM_BIT = XLEN - 5;

    logic [SW-1:0] sel_q;
    trig_ctrl_t    wr_c;
    logic          we_sel;
    logic          we_ctrl;
    logic          we_data;

    assign we_sel  = csr_we && (reg_addr_e'(csr_waddr) == RA_SEL);
    assign we_ctrl = csr_we && (reg_addr_e'(csr_waddr) == RA_CTRL);
    assign we_data = csr_we && (reg_addr_e'(csr_waddr) == RA_DATA);
    assign sel_o   = sel_q;

    // Index register; out-of-range values are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (we_sel && (csr_wdata < XLEN'(N)))
            sel_q <= csr_wdata[SW-1:0];
    end

    // Decode of the written word into a control record.
    always_comb begin
        wr_c.en_x   = csr_wdata[CB_EXE];
        wr_c.en_st  = csr_wdata[CB_ST];
        wr_c.en_ld  = csr_wdata[CB_LD];
        wr_c.en_u   = csr_wdata[CB_U];
        wr_c.en_s   = csr_wdata[CB_S];
        wr_c.en_m   = csr_wdata[CB_M];
        wr_c.mmode  = csr_wdata[CB_MATCH +: 4];
        wr_c.chain  = csr_wdata[CB_CHAIN];
        wr_c.action = csr_wdata[CB_ACT];
        wr_c.dmode  = csr_wdata[DM_BIT] && in_debug;
    end

    for (genvar i = 0; i < N; i++) begin : g_trig
        trig_ctrl_t      c_q;
        trig_ctrl_t      c_nxt;
        logic [XLEN-1:0] d_q;
        logic            prev_ch;
        logic            next_ch;
        logic            next_dm;
        logic            has_next;
        logic            may_chain;
        logic            tgt;
        logic            lock;

        if (i > 0) begin : g_p
            assign prev_ch = ctrl_o[i-1].chain;
        end else begin : g_np
            assign prev_ch = 1'b0;
        end

        if (i < N - 1) begin : g_n
            assign next_ch  = ctrl_o[i+1].chain;
            assign next_dm  = ctrl_o[i+1].dmode;
            assign has_next = 1'b1;
        end else begin : g_nn
            assign next_ch  = 1'b0;
            assign next_dm  = 1'b0;
            assign has_next = 1'b0;
        end

        assign may_chain = has_next && !prev_ch && !next_ch && (in_debug || !next_dm);
        assign tgt       = (sel_q == SW'(i));
        assign lock      = c_q.dmode && !in_debug;

        // New control value with the chain bit filtered by legality.
        always_comb begin
            c_nxt       = wr_c;
            c_nxt.chain = wr_c.chain && may_chain;
        end

        // Control and data storage, locked outside debug when debug-only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                c_q <= '0;
                d_q <= '0;
            end else if (tgt && !lock) begin
                if (we_ctrl)
                    c_q <= c_nxt;
                if (we_data)
                    d_q <= csr_wdata;
            end
        end

        assign ctrl_o[i] = c_q;
        assign data_o[i] = d_q;
    end

    // Re-encodes a stored control record as a register word.
    function automatic logic [XLEN-1:0] pack_ctrl(trig_ctrl_t c);
        logic [XLEN-1:0] w;
        w                  = '0;
        w[CB_EXE]          = c.en_x;
        w[CB_ST]           = c.en_st;
        w[CB_LD]           = c.en_ld;
        w[CB_U]            = c.en_u;
        w[CB_S]            = c.en_s;
        w[CB_M]            = c.en_m;
        w[CB_MATCH +: 4]   = c.mmode;
        w[CB_CHAIN]        = c.chain;
        w[CB_ACT]          = c.action;
        w[DM_BIT]          = c.dmode;
        return w;
    endfunction

    // Read multiplexer.
    always_comb begin
        unique case (reg_addr_e'(csr_raddr))
            RA_SEL:  csr_rdata = XLEN'(sel_q);
            RA_CTRL: csr_rdata = pack_ctrl(ctrl_o[sel_q]);
            RA_DATA: csr_rdata = data_o[sel_q];
            default: csr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/trig_unit.sv
`timescale 1ns/1ps
// Top of the chainable address-match trigger unit. Holds N triggers, compares
// each against the fetch and load/store ports in parallel and returns
// per-port breakpoint / debug-entry requests in the same cycle.
// Assumes one access per port per cycle and privilege codes 0/1/3.
module trig_unit
    import trig_pkg::*;
#(
    parameter int N    = 4,
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic [1:0]      csr_waddr,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic [1:0]      csr_raddr,
    output logic [XLEN-1:0] csr_rdata,
    input  logic            in_debug,
    input  logic [1:0]      priv,
    input  logic            if_valid,
    input  logic [XLEN-1:0] if_addr,
    input  logic            ls_valid,
    input  logic            ls_store,
    input  logic [XLEN-1:0] ls_addr,
    output logic [N-1:0]    hit,
    output logic            if_bkpt,
    output logic            if_dbg,
    output logic            ls_bkpt,
    output logic            ls_dbg
);

    localparam int SW = (N > 1) ? $clog2(N) : 1;

    logic [SW-1:0]          sel_w;
    trig_ctrl_t [N-1:0]     ctrl_w;
    logic [N-1:0][XLEN-1:0] data_w;
    logic [N-1:0]           if_m;
    logic [N-1:0]           ls_m;

    trig_regs #(.N(N), .XLEN(XLEN)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_waddr (csr_waddr),
        .csr_wdata (csr_wdata),
        .csr_raddr (csr_raddr),
        .in_debug  (in_debug),
        .csr_rdata (csr_rdata),
        .sel_o     (sel_w),
        .ctrl_o    (ctrl_w),
        .data_o    (data_w)
    );

    for (genvar i = 0; i < N; i++) begin : g_cmp
        // Fetch-port comparator.
        trig_match #(.XLEN(XLEN)) if_cmp_i (
            .ctrl      (ctrl_w[i]),
            .tval      (data_w[i]),
            .acc_valid (if_valid),
            .acc_addr  (if_addr),
            .acc_x     (1'b1),
            .acc_ld    (1'b0),
            .acc_st    (1'b0),
            .priv      (priv),
            .match     (if_m[i])
        );
        // Load/store-port comparator.
        trig_match #(.XLEN(XLEN)) ls_cmp_i (
            .ctrl      (ctrl_w[i]),
            .tval      (data_w[i]),
            .acc_valid (ls_valid),
            .acc_addr  (ls_addr),
            .acc_x     (1'b0),
            .acc_ld    (!ls_store),
            .acc_st    (ls_store),
            .priv      (priv),
            .match     (ls_m[i])
        );
    end

    trig_resolve #(.N(N)) if_res_i (
        .ctrl (ctrl_w),
        .m    (if_m),
        .bkpt (if_bkpt),
        .dbg  (if_dbg)
    );

    trig_resolve #(.N(N)) ls_res_i (
        .ctrl (ctrl_w),
        .m    (ls_m),
        .bkpt (ls_bkpt),
        .dbg  (ls_dbg)
    );

    assign hit = if_m | ls_m;

endmodule

// File: rtl/trig_unit_chk.sv
`timescale 1ns/1ps
// Property checker for trig_unit, attached by bind. Observes ports and the
// stored index, control and data values.
module trig_unit_chk
    import trig_pkg::*;
#(
    parameter int N    = 4,
    parameter int XLEN = 32,
    localparam int SW  = (N > 1) ? $clog2(N) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   csr_we,
    input logic [1:0]             csr_waddr,
    input logic                   in_debug,
    input logic                   if_valid,
    input logic                   ls_valid,
    input logic [N-1:0]           hit,
    input logic                   if_bkpt,
    input logic                   if_dbg,
    input logic                   ls_bkpt,
    input logic                   ls_dbg,
    input logic [SW-1:0]          sel,
    input trig_ctrl_t [N-1:0]     ctrl,
    input logic [N-1:0][XLEN-1:0] data
);

    a_r1_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(sel) < N);

    a_r5_if_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !if_valid |-> !(if_bkpt || if_dbg));

    a_r5_ls_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ls_valid |-> !(ls_bkpt || ls_dbg));

    a_r6_if_prec: assert property (@(posedge clk) disable iff (!rst_n)
        !(if_bkpt && if_dbg));

    a_r6_ls_prec: assert property (@(posedge clk) disable iff (!rst_n)
        !(ls_bkpt && ls_dbg));

    a_r11_req_has_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (if_bkpt || if_dbg || ls_bkpt || ls_dbg) |-> (hit != '0));

    a_r8_last_unchained: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[N-1].chain);

    for (genvar i = 0; i < N; i++) begin : g_chk
        if (i < N - 1) begin : g_pair
            a_r8_no_triple: assert property (@(posedge clk) disable iff (!rst_n)
                !(ctrl[i].chain && ctrl[i+1].chain));

            a_r9_chain_gate: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ctrl[i].chain) |-> ($past(in_debug) || !$past(ctrl[i+1].dmode)));
        end

        a_r10_lock: assert property (@(posedge clk) disable iff (!rst_n)
            (csr_we && !in_debug && ctrl[i].dmode && (sel == SW'(i)) &&
             (csr_waddr == 2'd1 || csr_waddr == 2'd2))
            |=> ($stable(ctrl[i]) && $stable(data[i])));

        a_r10_dmode_set: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ctrl[i].dmode) |-> $past(in_debug));
    end

endmodule

bind trig_unit trig_unit_chk #(.N(N), .XLEN(XLEN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .csr_waddr (csr_waddr),
    .in_debug  (in_debug),
    .if_valid  (if_valid),
    .ls_valid  (ls_valid),
    .hit       (hit),
    .if_bkpt   (if_bkpt),
    .if_dbg    (if_dbg),
    .ls_bkpt   (ls_bkpt),
    .ls_dbg    (ls_dbg),
    .sel       (sel_w),
    .ctrl      (ctrl_w),
    .data      (data_w)
);

// File: tb/trig_unit_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases then seeded random traffic,
// compared against a register model written from the requirements.
module trig_unit_tb_top;

    localparam int N    = 4;
    localparam int XLEN = 32;
    localparam int DM   = XLEN - 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            csr_we = 1'b0;
    logic [1:0]      csr_waddr = '0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [1:0]      csr_raddr = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            in_debug = 1'b0;
    logic [1:0]      priv = 2'd3;
    logic            if_valid = 1'b0;
    logic [XLEN-1:0] if_addr = '0;
    logic            ls_valid = 1'b0;
    logic            ls_store = 1'b0;
    logic [XLEN-1:0] ls_addr = '0;
    logic [N-1:0]    hit;
    logic            if_bkpt, if_dbg, ls_bkpt, ls_dbg;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [XLEN-1:0] mc [N];
    logic [XLEN-1:0] md [N];
    int              ms;

    always #4 clk = ~clk;

    trig_unit #(.N(N), .XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_waddr(csr_waddr),
        .csr_wdata(csr_wdata), .csr_raddr(csr_raddr), .csr_rdata(csr_rdata),
        .in_debug(in_debug), .priv(priv), .if_valid(if_valid), .if_addr(if_addr),
        .ls_valid(ls_valid), .ls_store(ls_store), .ls_addr(ls_addr), .hit(hit),
        .if_bkpt(if_bkpt), .if_dbg(if_dbg), .ls_bkpt(ls_bkpt), .ls_dbg(ls_dbg)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Control word builder (bit layout of R2).
    function automatic logic [XLEN-1:0] cw(bit x, bit st, bit ld, bit u, bit s, bit m,
                                           int mm, bit ch, bit act, bit dm);
        logic [XLEN-1:0] w = '0;
        w[0] = x; w[1] = st; w[2] = ld; w[3] = u; w[4] = s; w[5] = m;
        w[9:6] = 4'(mm); w[10] = ch; w[11] = act; w[DM] = dm;
        return w;
    endfunction

    // Register model update following R1, R2, R8, R9, R10.
    task automatic model_write(int a, logic [XLEN-1:0] wd, bit dbg);
        logic [XLEN-1:0] nw;
        bit ok;
        if (a == 0) begin
            if (wd < N) ms = int'(wd);
        end else if (a == 1 || a == 2) begin
            if (!(mc[ms][DM] && !dbg)) begin
                if (a == 2) md[ms] = wd;
                else begin
                    nw = wd & 32'h0000_0FFF;
                    nw[DM] = wd[DM] & dbg;
                    if (wd[10]) begin
                        ok = (ms < N - 1);
                        if (ok) ok = (dbg || !mc[ms+1][DM]) && !mc[ms+1][10];
                        if (ms > 0 && mc[ms-1][10]) ok = 0;
                        nw[10] = ok;
                    end
                    mc[ms] = nw;
                end
            end
        end
    endtask

    task automatic wr(int a, logic [XLEN-1:0] wd, bit dbg);
        @(negedge clk);
        csr_we = 1'b1; csr_waddr = 2'(a); csr_wdata = wd; in_debug = dbg;
        @(negedge clk);
        csr_we = 1'b0;
        model_write(a, wd, dbg);
    endtask

    // Per-trigger match per R3 and R4; kind 0 exec, 1 load, 2 store.
    function automatic bit mmatch(int i, logic [XLEN-1:0] a, int kind, logic [1:0] pr);
        logic [XLEN-1:0] c = mc[i];
        bit kok, pok, cok;
        kok = (kind == 0) ? c[0] : (kind == 1) ? c[2] : c[1];
        pok = (pr == 0) ? c[3] : (pr == 1) ? c[4] : (pr == 3) ? c[5] : 1'b0;
        case (c[9:6])
            4'd0:    cok = (a == md[i]);
            4'd2:    cok = (a >= md[i]);
            4'd3:    cok = (a < md[i]);
            default: cok = 1'b0;
        endcase
        return kok && pok && cok;
    endfunction

    // Request resolution per R5, R6, R7: returns {dbg, bkpt}.
    function automatic logic [1:0] resolve(logic [N-1:0] m);
        bit d = 0, b = 0;
        for (int i = 0; i < N; i++) begin
            if (mc[i][10]) continue;
            if (i > 0 && mc[i-1][10] && !m[i-1]) continue;
            if (m[i]) begin
                if (mc[i][11]) d = 1; else b = 1;
            end
        end
        return {d, b && !d};
    endfunction

    // Applies one access pair and compares all match outputs.
    task automatic acc(string tag, bit fv, logic [XLEN-1:0] fa, bit lv, bit lst,
                       logic [XLEN-1:0] la, logic [1:0] pr);
        logic [N-1:0] fm, lm;
        logic [1:0] fr, lr;
        @(negedge clk);
        if_valid = fv; if_addr = fa; ls_valid = lv; ls_store = lst; ls_addr = la; priv = pr;
        #1;
        for (int i = 0; i < N; i++) begin
            fm[i] = fv && mmatch(i, fa, 0, pr);
            lm[i] = lv && mmatch(i, la, lst ? 2 : 1, pr);
        end
        fr = resolve(fm);
        lr = resolve(lm);
        check(tag, 64'({hit, if_dbg, if_bkpt, ls_dbg, ls_bkpt}),
                   64'({fm | lm, fr, lr}));
    endtask

    // Reads back index, control and data of the indexed trigger.
    task automatic chk_regs(string tag);
        @(negedge clk);
        csr_raddr = 2'd0; #1; check({tag, " sel"}, 64'(csr_rdata), 64'(ms));
        csr_raddr = 2'd1; #1; check({tag, " ctrl"}, 64'(csr_rdata), 64'(mc[ms]));
        csr_raddr = 2'd2; #1; check({tag, " data"}, 64'(csr_rdata), 64'(md[ms]));
        csr_raddr = 2'd3; #1; check({tag, " none"}, 64'(csr_rdata), 64'(0));
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) begin
            wr(0, i, 1'b1);
            wr(1, '0, 1'b1);
            wr(2, '0, 1'b1);
        end
        wr(0, 0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'h5eed_1234);
        for (int i = 0; i < N; i++) begin mc[i] = '0; md[i] = '0; end
        ms = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R12 reset state
        chk_regs("R12 reset");
        acc("R12 reset outputs", 1, 0, 1, 0, 0, 2'd3);

        // R3/R4/R5 equality on fetch, trigger 0
        wr(2, 32'h40, 0);
        wr(1, cw(1,0,0,0,0,1, 0, 0,0,0), 0);
        chk_regs("R2 readback");
        acc("R5 fetch bkpt", 1, 32'h40, 0, 0, 0, 2'd3);
        check("R5 literal bkpt", 64'({if_bkpt, if_dbg}), 64'(2'b10));
        acc("R3 eq miss", 1, 32'h41, 0, 0, 0, 2'd3);
        acc("R4 priv U off", 1, 32'h40, 0, 0, 0, 2'd0);
        acc("R4 priv rsv", 1, 32'h40, 0, 0, 0, 2'd2);
        acc("R4 load kind off", 0, 0, 1, 0, 32'h40, 2'd3);
        acc("R5 valid low", 0, 32'h40, 0, 0, 32'h40, 2'd3);

        // R3 ge/lt boundaries on trigger 1, debug action
        wr(0, 1, 0);
        wr(2, 32'h80, 0);
        wr(1, cw(0,1,1,1,1,1, 2, 0,1,0), 0);
        acc("R3 ge at bound", 0, 0, 1, 1, 32'h80, 2'd1);
        check("R5 literal dbg", 64'({ls_dbg, ls_bkpt}), 64'(2'b10));
        acc("R3 ge below", 0, 0, 1, 0, 32'h7F, 2'd0);
        wr(1, cw(0,1,1,1,1,1, 3, 0,1,0), 0);
        acc("R3 lt below", 0, 0, 1, 0, 32'h7F, 2'd3);
        acc("R3 lt at bound", 0, 0, 1, 1, 32'h80, 2'd3);
        wr(1, cw(0,1,1,1,1,1, 5, 0,1,0), 0);
        acc("R3 mode 5 never", 0, 0, 1, 0, 32'h0, 2'd3);

        // R6 precedence: trigger 0 bkpt and trigger 1 dbg both on a load
        wr(0, 0, 0);
        wr(1, cw(0,0,1,0,0,1, 0, 0,0,0), 0);
        wr(0, 1, 0);
        wr(2, 32'h10, 0);
        wr(1, cw(0,0,1,0,0,1, 2, 0,1,0), 0);
        acc("R6 dbg over bkpt", 0, 0, 1, 0, 32'h40, 2'd3);
        check("R6 literal", 64'({ls_dbg, ls_bkpt}), 64'(2'b10));
        acc("R11 hit both", 0, 0, 1, 0, 32'h40, 2'd3);

        // R7 chain window on triggers 2,3
        clear_all();
        wr(0, 2, 0); wr(2, 32'h100, 0); wr(1, cw(1,0,0,0,0,1, 2, 1,0,0), 0);
        chk_regs("R8 legal chain");
        wr(0, 3, 0); wr(2, 32'h200, 0); wr(1, cw(1,0,0,0,0,1, 3, 0,1,0), 0);
        acc("R7 inside window", 1, 32'h150, 0, 0, 0, 2'd3);
        check("R7 literal", 64'({if_dbg, if_bkpt}), 64'(2'b10));
        acc("R7 above window", 1, 32'h250, 0, 0, 0, 2'd3);
        check("R7 first silent", 64'({if_dbg, if_bkpt}), 64'(2'b00));
        acc("R7 below window", 1, 32'h50, 0, 0, 0, 2'd3);
        check("R11 hit lone", 64'(hit), 64'(4'b1000));

        // R8 illegal chain requests
        wr(1, cw(1,0,0,0,0,1, 3, 1,1,0), 0);
        chk_regs("R8 last trigger");
        wr(0, 1, 0); wr(1, cw(1,0,0,0,0,1, 0, 1,0,0), 0);
        chk_regs("R8 next chained");
        wr(0, 3, 0); wr(1, cw(0,0,0,0,0,0, 0, 0,0,0), 0);
        wr(0, 2, 0); wr(1, cw(0,0,0,0,0,0, 0, 0,0,0), 0);
        wr(0, 1, 0); wr(1, cw(0,0,0,0,0,0, 0, 1,0,0), 0);
        wr(0, 2, 0); wr(1, cw(1,0,0,0,0,1, 0, 1,0,0), 0);
        chk_regs("R8 prev chained");

        // R10 debug-only lock and R9 chain gating
        clear_all();
        wr(0, 1, 1); wr(2, 32'h33, 1); wr(1, cw(1,0,0,0,0,1, 0, 0,0,1), 1);
        chk_regs("R10 dmode set in debug");
        wr(1, cw(1,1,1,1,1,1, 2, 0,1,0), 0);
        wr(2, 32'h99, 0);
        chk_regs("R10 locked outside debug");
        wr(0, 2, 0); wr(1, cw(1,0,0,0,0,1, 0, 0,0,1), 0);
        chk_regs("R10 dmode not settable");
        wr(0, 0, 0); wr(1, cw(1,0,0,0,0,1, 0, 1,0,0), 0);
        chk_regs("R9 next dmode blocks");
        wr(1, cw(1,0,0,0,0,1, 0, 1,0,0), 1);
        chk_regs("R9 debug allows");

        // R1 index range and dead address
        wr(0, 7, 0);
        chk_regs("R1 index out of range");
        wr(3, 32'hFFFF_FFFF, 0);
        chk_regs("R1 dead address");

        // Random traffic
        clear_all();
        for (int it = 0; it < 600; it++) begin
            int k = $urandom_range(0, 9);
            if (k < 4) begin
                int a = $urandom_range(0, 3);
                logic [XLEN-1:0] wd;
                bit dbg = ($urandom_range(0, 3) == 0);
                if (a == 0)      wd = $urandom_range(0, 5);
                else if (a == 1) begin
                    wd = $urandom & 32'h0000_0FFF;
                    if ($urandom_range(0, 3) != 0) wd[9:6] = 4'($urandom_range(0, 3));
                    wd[DM] = ($urandom_range(0, 5) == 0);
                end else         wd = $urandom_range(0, 63);
                wr(a, wd, dbg);
                if (k == 0) chk_regs("R2 random regs");
            end else begin
                acc("R11 random access", $urandom_range(0, 1), $urandom_range(0, 63),
                    $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 63),
                    2'($urandom_range(0, 3)));
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule